// File: doc/BRIEF.md
# SD Command-Line Short Response Receiver

This block listens to the single-bit command line of an SD host and captures the 48-bit short response that a card returns after a command. The command sequencer pulses a strobe when it has finished sending a command. The receiver then lets the bus-turnaround bits pass and searches a programmable window for the card's start bit. It shifts in the whole frame, most significant bit first, with one bit for each rising edge of the host clock.

When the frame is complete, the block checks four things: the transmission bit, the end bit, the command index against the index the host expects, and the CRC7 carried in the frame. It also splits the frame as a published-address response. The 16-bit relative card address goes out on one port. The 16 compacted status bits are expanded back to their positions in a 32-bit card status word. One valid pulse reports the outcome and carries the error flags. If no start bit appears within the window, the same pulse carries a timeout flag instead.

Top module: `sd_rsp_rx`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rsp_valid_o`, all four error flags, `rca_o` and `card_status_o` are zero.
- R2: After `cmd_done_i` is sampled high in idle, the next two samples of `cmd_i` are turnaround bits. They are ignored even when low.
- R3: The first low sample among the next `max_wait_i` samples (1 to 64) is taken as the start bit (frame bit 47). A start bit on the last permitted sample is accepted.
- R4: If all `max_wait_i` window samples are high, `rsp_valid_o` pulses with only `err_tmo_o` set. `rca_o` and `card_status_o` keep their previous values.
- R5: A frame is 48 bits, most significant bit first. `rsp_valid_o` is high for exactly one cycle, starting on the clock edge that samples frame bit 0.
- R6: On a completed frame, `rca_o` takes frame bits 39:24.
- R7: On a completed frame, `card_status_o` is rebuilt from frame bits 23:8 as follows. Frame bit 23 goes to status bit 23, frame bit 22 goes to status bit 22, frame bit 21 goes to status bit 19, and frame bits 20:8 go to status bits 12:0. All other status bits are zero.
- R8: `err_crc_o` is set when frame bits 7:1 differ from the CRC7 (generator x^7+x^3+1, register cleared at the start bit) of frame bits 47:8.
- R9: `err_frame_o` is set when frame bit 46 is 1 or frame bit 0 is 0.
- R10: `err_idx_o` is set when frame bits 45:40 differ from `exp_idx_i`.
- R11: `cmd_done_i` is ignored unless the receiver is idle. A strobe in mid-frame neither restarts reception nor adds a result.
- R12: The error flags are low whenever `rsp_valid_o` is low. `rca_o` changes only with a valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; the line is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 1 | Sampled command line |
| cmd_done_i | input | 1 | One-cycle strobe: a command has just been sent |
| exp_idx_i | input | 6 | Command index expected in the response |
| max_wait_i | input | 7 | Number of samples (1..64) in which to search for the start bit |
| rsp_valid_o | output | 1 | One-cycle result pulse |
| rca_o | output | 16 | Relative card address from the last frame |
| card_status_o | output | 32 | Expanded card status from the last frame |
| err_crc_o | output | 1 | CRC7 mismatch |
| err_frame_o | output | 1 | Transmission or end bit wrong |
| err_idx_o | output | 1 | Command index mismatch |
| err_tmo_o | output | 1 | No start bit within the window |

## Verification
The start-bit search and the timeout expiry compete on the last sample of the window. The bench places the card's start bit exactly on sample `max_wait_i` and expects a normal frame. It then places the start bit one sample later and expects a lone timeout, with the address and status unchanged. The CRC, framing and index checks all evaluate on the same final edge. The bench provokes them one at a time and also together, and compares the full flag set of every pulse against a predicted item in its scoreboard.

// File: rtl/sd_rsp_pkg.sv
package sd_rsp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TURN,
    ST_WAIT,
    ST_RECV
  } rx_state_t;

  localparam int CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

endpackage

// File: rtl/sd_crc7_ser.sv
module sd_crc7_ser
  import sd_rsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);

  logic fb;
  assign fb = crc_o[CRC_W-1] ^ bit_i;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc_o <= '0;
    end else if (en) begin
      crc_o <= {crc_o[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
  end

endmodule

// File: rtl/sd_rsp_unpack.sv
module sd_rsp_unpack
  import sd_rsp_pkg::*;
#(
  parameter int FRAME_W = 48,
  parameter int IDX_W   = 6,
  parameter int RCA_W   = 16,
  parameter int STAT_W  = 32
) (
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CRC_W-1:0]   crc_calc_i,
  input  logic [IDX_W-1:0]   exp_idx_i,
  output logic [RCA_W-1:0]   rca_o,
  output logic [STAT_W-1:0]  status_o,
  output logic               e_crc_o,
  output logic               e_frame_o,
  output logic               e_idx_o
);

  localparam int TX_POS  = FRAME_W - 2;
  localparam int IDX_LO  = TX_POS - IDX_W;
  localparam int RCA_LO  = IDX_LO - RCA_W;
  localparam int ST_LO   = CRC_W + 1;
  localparam int LOW_CNT = 13;

  assign rca_o = frame_i[RCA_LO +: RCA_W];

  always_comb begin
    status_o                = '0;
    status_o[LOW_CNT-1:0]   = frame_i[ST_LO +: LOW_CNT];
    status_o[19]            = frame_i[ST_LO + LOW_CNT];
    status_o[22]            = frame_i[ST_LO + LOW_CNT + 1];
    status_o[23]            = frame_i[ST_LO + LOW_CNT + 2];
  end

  assign e_frame_o = frame_i[TX_POS] | ~frame_i[0];
  assign e_idx_o   = frame_i[IDX_LO +: IDX_W] != exp_idx_i;
  assign e_crc_o   = frame_i[1 +: CRC_W] != crc_calc_i;

endmodule

// File: rtl/sd_rsp_rx.sv
module sd_rsp_rx
  import sd_rsp_pkg::*;
#(
  parameter int FRAME_W   = 48,
  parameter int IDX_W     = 6,
  parameter int RCA_W     = 16,
  parameter int STAT_W    = 32,
  parameter int WAIT_W    = 7,
  parameter int TURN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_i,
  input  logic              cmd_done_i,
  input  logic [IDX_W-1:0]  exp_idx_i,
  input  logic [WAIT_W-1:0] max_wait_i,
  output logic              rsp_valid_o,
  output logic [RCA_W-1:0]  rca_o,
  output logic [STAT_W-1:0] card_status_o,
  output logic              err_crc_o,
  output logic              err_frame_o,
  output logic              err_idx_o,
  output logic              err_tmo_o
);

  localparam int CNT_W    = $clog2(FRAME_W);
  localparam int TURN_W   = (TURN_BITS > 1) ? $clog2(TURN_BITS) : 1;
  localparam int CRC_SPAN = FRAME_W - CRC_W - 1;

  rx_state_t          state;
  logic [TURN_W-1:0]  tcnt;
  logic [WAIT_W-1:0]  wcnt;
  logic [CNT_W-1:0]   bcnt;
  logic [FRAME_W-2:0] shreg;
  logic [FRAME_W-1:0] frame_w;
  logic [CRC_W-1:0]   crc_w;
  logic               crc_clr, crc_en;
  logic [RCA_W-1:0]   rca_w;
  logic [STAT_W-1:0]  stat_w;
  logic               e_crc_w, e_frame_w, e_idx_w;

  assign frame_w = {shreg, cmd_i};
  assign crc_clr = (state == ST_WAIT) && !cmd_i;
  assign crc_en  = (state == ST_RECV) && (bcnt < CNT_W'(CRC_SPAN));

  sd_crc7_ser u_crc (
    .clk   (clk),
    .rst   (rst),
    .clr   (crc_clr),
    .en    (crc_en),
    .bit_i (cmd_i),
    .crc_o (crc_w)
  );

  sd_rsp_unpack #(
    .FRAME_W (FRAME_W),
    .IDX_W   (IDX_W),
    .RCA_W   (RCA_W),
    .STAT_W  (STAT_W)
  ) u_unpack (
    .frame_i    (frame_w),
    .crc_calc_i (crc_w),
    .exp_idx_i  (exp_idx_i),
    .rca_o      (rca_w),
    .status_o   (stat_w),
    .e_crc_o    (e_crc_w),
    .e_frame_o  (e_frame_w),
    .e_idx_o    (e_idx_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      tcnt          <= '0;
      wcnt          <= '0;
      bcnt          <= '0;
      shreg         <= '0;
      rsp_valid_o   <= 1'b0;
      rca_o         <= '0;
      card_status_o <= '0;
      err_crc_o     <= 1'b0;
      err_frame_o   <= 1'b0;
      err_idx_o     <= 1'b0;
      err_tmo_o     <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      err_crc_o   <= 1'b0;
      err_frame_o <= 1'b0;
      err_idx_o   <= 1'b0;
      err_tmo_o   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_done_i) begin
            state <= ST_TURN;
            tcnt  <= '0;
          end
        end
        ST_TURN: begin
          if (tcnt == TURN_W'(TURN_BITS - 1)) begin
            state <= ST_WAIT;
            wcnt  <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (!cmd_i) begin
            state <= ST_RECV;
            bcnt  <= CNT_W'(1);
            shreg <= '0;
          end else if (wcnt + 1'b1 == max_wait_i) begin
            state       <= ST_IDLE;
            rsp_valid_o <= 1'b1;
            err_tmo_o   <= 1'b1;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_RECV: begin
          shreg <= {shreg[FRAME_W-3:0], cmd_i};
          bcnt  <= bcnt + 1'b1;
          if (bcnt == CNT_W'(FRAME_W - 1)) begin
            state         <= ST_IDLE;
            rsp_valid_o   <= 1'b1;
            rca_o         <= rca_w;
            card_status_o <= stat_w;
            err_crc_o     <= e_crc_w;
            err_frame_o   <= e_frame_w;
            err_idx_o     <= e_idx_w;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sd_rsp_rx_chk.sv
module sd_rsp_rx_chk #(
  parameter int RCA_W  = 16,
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rsp_valid_o,
  input logic [RCA_W-1:0]  rca_o,
  input logic [STAT_W-1:0] card_status_o,
  input logic              err_crc_o,
  input logic              err_frame_o,
  input logic              err_idx_o,
  input logic              err_tmo_o
);

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |=> !rsp_valid_o); // R5

  AST_TMO_ALONE: assert property (@(posedge clk) disable iff (rst)
    err_tmo_o |-> (rsp_valid_o && !err_crc_o && !err_frame_o && !err_idx_o)); // R4

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid_o |-> !(err_crc_o || err_frame_o || err_idx_o || err_tmo_o)); // R12

  AST_RCA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid_o |-> $stable(rca_o)); // R12

  AST_TMO_KEEPS_STATUS: assert property (@(posedge clk) disable iff (rst)
    err_tmo_o |-> ($stable(rca_o) && $stable(card_status_o))); // R4

endmodule

bind sd_rsp_rx sd_rsp_rx_chk #(
  .RCA_W  (RCA_W),
  .STAT_W (STAT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .rsp_valid_o   (rsp_valid_o),
  .rca_o         (rca_o),
  .card_status_o (card_status_o),
  .err_crc_o     (err_crc_o),
  .err_frame_o   (err_frame_o),
  .err_idx_o     (err_idx_o),
  .err_tmo_o     (err_tmo_o)
);

// File: tb/sd_rsp_rx_bench.sv
module sd_rsp_rx_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_i = 1'b1;
  logic        cmd_done_i = 1'b0;
  logic [5:0]  exp_idx_i = 6'd3;
  logic [6:0]  max_wait_i = 7'd64;
  logic        rsp_valid_o;
  logic [15:0] rca_o;
  logic [31:0] card_status_o;
  logic        err_crc_o, err_frame_o, err_idx_o, err_tmo_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] rca;
    logic [31:0] st;
    logic        crc, frm, idx, tmo;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [15:0] last_rca = '0;
  logic [31:0] last_st  = '0;

  always #2 clk = ~clk;

  sd_rsp_rx u_sd_rsp_rx (
    .clk           (clk),
    .rst           (rst),
    .cmd_i         (cmd_i),
    .cmd_done_i    (cmd_done_i),
    .exp_idx_i     (exp_idx_i),
    .max_wait_i    (max_wait_i),
    .rsp_valid_o   (rsp_valid_o),
    .rca_o         (rca_o),
    .card_status_o (card_status_o),
    .err_crc_o     (err_crc_o),
    .err_frame_o   (err_frame_o),
    .err_idx_o     (err_idx_o),
    .err_tmo_o     (err_tmo_o)
  );

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = c[6] ^ d[i];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [31:0] expand(input logic [15:0] s);
    logic [31:0] w;
    w        = '0;
    w[23]    = s[15];
    w[22]    = s[14];
    w[19]    = s[13];
    w[12:0]  = s[12:0];
    return w;
  endfunction

  task automatic check(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  // monitor: pops scoreboard items on every result pulse
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid_o && !finished) begin
        if (sb.size() == 0) begin
          check(0, "R11 unexpected result pulse", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({err_crc_o, err_frame_o, err_idx_o, err_tmo_o} ===
                {e.crc, e.frm, e.idx, e.tmo},
                {e.tag, " flags"},
                {60'd0, err_crc_o, err_frame_o, err_idx_o, err_tmo_o},
                {60'd0, e.crc, e.frm, e.idx, e.tmo});
          check(rca_o === e.rca, {e.tag, " R6 rca"}, {48'd0, rca_o}, {48'd0, e.rca});
          check(card_status_o === e.st, {e.tag, " R7 status"},
                {32'd0, card_status_o}, {32'd0, e.st});
          @(negedge clk);
          check(!rsp_valid_o, {e.tag, " R5 single pulse"}, {63'd0, rsp_valid_o}, 64'd0);
          check(!(err_crc_o | err_frame_o | err_idx_o | err_tmo_o), {e.tag, " R12 quiet"},
                {60'd0, err_crc_o, err_frame_o, err_idx_o, err_tmo_o}, 64'd0);
        end
      end
    end
  end

  task automatic run_rsp(input logic [5:0] idx, input logic [15:0] rca, input logic [15:0] st,
                         input bit tbit, input bit endb, input bit bad_crc, input int gap,
                         input logic [1:0] turn, input int mw, input bit poke, input string tag);
    logic [47:0] f;
    exp_t e;
    f        = '0;
    f[47]    = 1'b0;
    f[46]    = tbit;
    f[45:40] = idx;
    f[39:24] = rca;
    f[23:8]  = st;
    f[7:1]   = crc7(f[47:8]) ^ (bad_crc ? 7'h01 : 7'h00);
    f[0]     = endb;
    max_wait_i = 7'(mw);
    e.tag = tag;
    if (gap >= mw) begin
      e.rca = last_rca; e.st = last_st;
      e.crc = 0; e.frm = 0; e.idx = 0; e.tmo = 1;
    end else begin
      e.rca = rca; e.st = expand(st);
      e.crc = bad_crc; e.frm = tbit | ~endb; e.idx = (idx != exp_idx_i); e.tmo = 0;
      last_rca = rca; last_st = expand(st);
    end
    sb.push_back(e);
    @(negedge clk); cmd_done_i = 1'b1;
    @(negedge clk); cmd_done_i = 1'b0; cmd_i = turn[1];
    @(negedge clk); cmd_i = turn[0];
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); cmd_i = 1'b1;
    end
    if (gap < mw) begin
      for (int i = 47; i >= 0; i--) begin
        @(negedge clk);
        cmd_i = f[i];
        cmd_done_i = poke && (i == 20);
      end
    end
    @(negedge clk); cmd_i = 1'b1; cmd_done_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!rsp_valid_o && rca_o == 0 && card_status_o == 0 &&
          !(err_crc_o | err_frame_o | err_idx_o | err_tmo_o), "R1 reset outputs",
          {31'd0, rsp_valid_o, rca_o, 16'd0}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!rsp_valid_o && rca_o == 0 && card_status_o == 0, "R1 after reset",
          {31'd0, rsp_valid_o, rca_o, 16'd0}, 64'd0);

    run_rsp(6'd3, 16'hA5C3, 16'h1234, 0, 1, 0, 5, 2'b11, 64, 0, "R3 R6 R7 good");
    run_rsp(6'd3, 16'h0F0F, 16'hFFFF, 0, 1, 1, 2, 2'b11, 64, 0, "R8 crc");
    run_rsp(6'd3, 16'h1111, 16'h8001, 1, 1, 0, 2, 2'b11, 64, 0, "R9 tx bit");
    run_rsp(6'd3, 16'h2222, 16'h4002, 0, 0, 0, 2, 2'b11, 64, 0, "R9 end bit");
    run_rsp(6'd2, 16'h3333, 16'h2004, 0, 1, 0, 2, 2'b11, 64, 0, "R10 index");
    run_rsp(6'd7, 16'h4444, 16'h0008, 1, 0, 1, 2, 2'b11, 64, 0, "R8 R9 R10 all");
    run_rsp(6'd3, 16'hBEEF, 16'h5A5A, 0, 1, 0, 0, 2'b00, 10, 0, "R2 turnaround low");
    run_rsp(6'd3, 16'hCAFE, 16'hA5A5, 0, 1, 0, 7, 2'b11, 8, 0, "R3 last sample");
    run_rsp(6'd3, 16'hDEAD, 16'h0000, 0, 1, 0, 8, 2'b11, 8, 0, "R4 timeout");
    run_rsp(6'd3, 16'h1357, 16'hE000, 0, 1, 0, 63, 2'b11, 64, 0, "R3 window 64");
    run_rsp(6'd3, 16'h2468, 16'h0000, 0, 1, 0, 64, 2'b11, 64, 0, "R4 timeout 64");
    run_rsp(6'd3, 16'h7777, 16'h1FFF, 0, 1, 0, 3, 2'b11, 64, 1, "R11 strobe mid-frame");
    run_rsp(6'd3, 16'h9999, 16'h6000, 0, 1, 0, 1, 2'b10, 64, 0, "R5 R7 after");

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R5 all results seen", 64'(sb.size()), 64'd0);
    check(rca_o === last_rca, "R12 rca held", {48'd0, rca_o}, {48'd0, last_rca});
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R5 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule